// File: doc/BRIEF.md
# VLAN Violation Capture Unit

This block sits beside the VLAN table lookup of a switch. Each cycle the lookup logic can report two kinds of policy event: a miss, meaning no table entry exists for the frame's VLAN ID, and a member violation, meaning the ingress port is not a member of that VLAN. Each event arrives as a one-cycle strobe that carries the source port number and the 13-bit VLAN ID.

The unit holds one violation at a time. While it holds one, it drives a level interrupt toward the host. The host collects the details with a get-and-clear command. The command loads the source port and the event flags into the operation register image and the VLAN ID into the VID register image, then frees the slot. Events that arrive while the slot is occupied are dropped. A sticky overflow flag records that at least one event was dropped.

Top module: `vlan_viol_capture`

## Requirements
- R1: After reset, irq_o, done_o, op_reg_o and vid_reg_o are all zero.
- R2: A miss strobe while the slot is empty sets irq_o from the next cycle. A later get-and-clear reports the port in op_reg_o[3:0] and sets the miss flag op_reg_o[9], with op_reg_o[8] clear.
- R3: A member strobe while the slot is empty is captured the same way, and get-and-clear sets the member flag op_reg_o[8] with op_reg_o[9] clear.
- R4: vid_reg_o carries VID bits 11:0 in bits 11:0 and VID bit 12 in bit 13. All other bits are zero.
- R5: A get-and-clear is cmd_vld_i with cmd_op_i = 3'b111. In the next cycle done_o is high for one cycle and op_reg_o[14:12] holds 3'b111.
- R6: irq_o is low in the cycle done_o is high, unless an event arrived together with the command.
- R7: While a violation is held, later strobes are not captured, and the overflow flag op_reg_o[10] is reported at the next get-and-clear. That command also clears the flag.
- R8: If miss and member strobes on different ports arrive in the same cycle, only the lower port is captured with its own flag and VID, and the overflow flag is set.
- R9: If both strobes arrive in the same cycle on the same port, both flags are set and the miss VID is kept.
- R10: A strobe in the same cycle as get-and-clear is captured into the freed slot. The readout reports the old violation, and irq_o stays high.
- R11: A get-and-clear with nothing held reports all flags, the port and the VID as zero.
- R12: A command with any other opcode is ignored: no done_o, and irq_o, op_reg_o and vid_reg_o are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_vld_i | input | 1 | Table-miss strobe |
| miss_port_i | input | 4 | Source port of the miss |
| miss_vid_i | input | 13 | VLAN ID of the miss |
| mbr_vld_i | input | 1 | Membership-violation strobe |
| mbr_port_i | input | 4 | Source port of the member violation |
| mbr_vid_i | input | 13 | VLAN ID of the member violation |
| cmd_vld_i | input | 1 | Host command strobe |
| cmd_op_i | input | 3 | Host command opcode |
| done_o | output | 1 | Command completed (one cycle) |
| op_reg_o | output | 16 | Operation register image |
| vid_reg_o | output | 16 | VID register image |
| irq_o | output | 1 | Level interrupt, high while a violation is held |

## Verification
The capture path is tried with five input patterns: a lone miss, a lone member violation with the page bit of the VID set, a second event that arrives while the slot is occupied, simultaneous strobes on different ports, and simultaneous strobes on one port. Between them these patterns separate the two flags, the VID encoding, the overflow path and the port arbitration. Three further patterns cover the host side: a command issued in the same cycle as a new event, a command with a foreign opcode, and a get-and-clear on an empty slot. These show whether clearing and capturing interact correctly.

// File: rtl/vvc_pkg.sv
package vvc_pkg;
    localparam int NPORT  = 11;
    localparam int PORT_W = $clog2(NPORT);
    localparam int VID_W  = 13;

    localparam logic [2:0] OP_GET_CLR = 3'b111;

    localparam int MEMBER_BIT = 8;
    localparam int MISS_BIT   = 9;
    localparam int OVF_BIT    = 10;
    localparam int PAGE_BIT   = 13;

    typedef struct packed {
        logic              miss;
        logic              member;
        logic [PORT_W-1:0] port;
        logic [VID_W-1:0]  vid;
    } viol_t;

    function automatic logic [15:0] enc_vid(input logic [VID_W-1:0] v);
        logic [15:0] r;
        r = '0;
        r[11:0] = v[11:0];
        r[PAGE_BIT] = v[12];
        return r;
    endfunction

    function automatic logic [15:0] enc_op(input viol_t rec, input logic ovf);
        logic [15:0] r;
        r = '0;
        r[PORT_W-1:0] = rec.port;
        r[MEMBER_BIT] = rec.member;
        r[MISS_BIT]   = rec.miss;
        r[OVF_BIT]    = ovf;
        r[14:12]      = OP_GET_CLR;
        return r;
    endfunction
endpackage

// File: rtl/vvc_arbiter.sv
module vvc_arbiter
    import vvc_pkg::*;
(
    input  logic              miss_vld,
    input  logic [PORT_W-1:0] miss_port,
    input  logic [VID_W-1:0]  miss_vid,
    input  logic              mbr_vld,
    input  logic [PORT_W-1:0] mbr_port,
    input  logic [VID_W-1:0]  mbr_vid,
    output logic              cand_vld,
    output viol_t             cand,
    output logic              cand_lost
);
    always_comb begin
        cand      = '0;
        cand_vld  = miss_vld | mbr_vld;
        cand_lost = 1'b0;
        if (miss_vld && mbr_vld) begin
            if (miss_port == mbr_port) begin
                cand.miss   = 1'b1;
                cand.member = 1'b1;
                cand.port   = miss_port;
                cand.vid    = miss_vid;
            end else if (miss_port < mbr_port) begin
                cand.miss   = 1'b1;
                cand.port   = miss_port;
                cand.vid    = miss_vid;
                cand_lost   = 1'b1;
            end else begin
                cand.member = 1'b1;
                cand.port   = mbr_port;
                cand.vid    = mbr_vid;
                cand_lost   = 1'b1;
            end
        end else if (miss_vld) begin
            cand.miss = 1'b1;
            cand.port = miss_port;
            cand.vid  = miss_vid;
        end else if (mbr_vld) begin
            cand.member = 1'b1;
            cand.port   = mbr_port;
            cand.vid    = mbr_vid;
        end
    end
endmodule

// File: rtl/vvc_holder.sv
module vvc_holder
    import vvc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  cand_vld,
    input  viol_t cand,
    input  logic  cand_lost,
    output logic  held,
    output viol_t rec,
    output logic  ovf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
            rec  <= '0;
            ovf  <= 1'b0;
        end else if (clr) begin
            held <= cand_vld;
            rec  <= cand;
            ovf  <= cand_lost;
        end else if (!held) begin
            if (cand_vld) begin
                held <= 1'b1;
                rec  <= cand;
                ovf  <= cand_lost;
            end
        end else if (cand_vld) begin
            ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/vvc_readout.sv
module vvc_readout
    import vvc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  viol_t       rec,
    input  logic        ovf,
    output logic        done,
    output logic [15:0] op_q,
    output logic [15:0] vid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            op_q  <= '0;
            vid_q <= '0;
        end else begin
            done <= clr;
            if (clr) begin
                op_q  <= enc_op(rec, ovf);
                vid_q <= enc_vid(rec.vid);
            end
        end
    end
endmodule

// File: rtl/vlan_viol_capture.sv
module vlan_viol_capture
    import vvc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_vld_i,
    input  logic [PORT_W-1:0] miss_port_i,
    input  logic [VID_W-1:0]  miss_vid_i,
    input  logic              mbr_vld_i,
    input  logic [PORT_W-1:0] mbr_port_i,
    input  logic [VID_W-1:0]  mbr_vid_i,
    input  logic              cmd_vld_i,
    input  logic [2:0]        cmd_op_i,
    output logic              done_o,
    output logic [15:0]       op_reg_o,
    output logic [15:0]       vid_reg_o,
    output logic              irq_o
);
    logic  cand_vld, cand_lost, held, ovf, clr;
    viol_t cand, rec;

    assign clr = cmd_vld_i && (cmd_op_i == OP_GET_CLR);

    vvc_arbiter u_arb (
        .miss_vld (miss_vld_i), .miss_port(miss_port_i), .miss_vid(miss_vid_i),
        .mbr_vld  (mbr_vld_i),  .mbr_port (mbr_port_i),  .mbr_vid (mbr_vid_i),
        .cand_vld (cand_vld),   .cand     (cand),        .cand_lost(cand_lost)
    );

    vvc_holder u_hold (
        .clk(clk), .rst(rst), .clr(clr),
        .cand_vld(cand_vld), .cand(cand), .cand_lost(cand_lost),
        .held(held), .rec(rec), .ovf(ovf)
    );

    vvc_readout u_rd (
        .clk(clk), .rst(rst), .clr(clr), .rec(rec), .ovf(ovf),
        .done(done_o), .op_q(op_reg_o), .vid_q(vid_reg_o)
    );

    assign irq_o = held;
endmodule

// File: rtl/vvc_chk.sv
module vvc_chk
    import vvc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        miss_vld_i,
    input logic        mbr_vld_i,
    input logic        cmd_vld_i,
    input logic [2:0]  cmd_op_i,
    input logic        done_o,
    input logic [15:0] op_reg_o,
    input logic [15:0] vid_reg_o,
    input logic        irq_o
);
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o == $past(cmd_vld_i && cmd_op_i == OP_GET_CLR));
    // R6
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld_i && cmd_op_i == OP_GET_CLR && !miss_vld_i && !mbr_vld_i) |=> !irq_o);
    // R2
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(miss_vld_i || mbr_vld_i));
    // R7
    ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && op_reg_o[OVF_BIT]) |-> (op_reg_o[MISS_BIT] || op_reg_o[MEMBER_BIT]));
    // R12
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(op_reg_o) && $stable(vid_reg_o)));
    // R4
    vid_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (vid_reg_o[15:14] == 2'b00) && (vid_reg_o[12] == 1'b0));
endmodule

bind vlan_viol_capture vvc_chk u_chk (
    .clk(clk), .rst(rst), .miss_vld_i(miss_vld_i), .mbr_vld_i(mbr_vld_i),
    .cmd_vld_i(cmd_vld_i), .cmd_op_i(cmd_op_i), .done_o(done_o),
    .op_reg_o(op_reg_o), .vid_reg_o(vid_reg_o), .irq_o(irq_o)
);

// File: tb/tb_vlan_viol_capture.sv
module tb_vlan_viol_capture;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        miss_vld_i = 1'b0, mbr_vld_i = 1'b0, cmd_vld_i = 1'b0;
    logic [3:0]  miss_port_i = '0, mbr_port_i = '0;
    logic [12:0] miss_vid_i = '0, mbr_vid_i = '0;
    logic [2:0]  cmd_op_i = '0;
    logic        done_o, irq_o;
    logic [15:0] op_reg_o, vid_reg_o;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vlan_viol_capture dut (.*);

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic evt(input bit mv, input int mp, input int mvid,
                       input bit bv, input int bp, input int bvid);
        @(negedge clk);
        miss_vld_i = mv; miss_port_i = 4'(mp); miss_vid_i = 13'(mvid);
        mbr_vld_i = bv;  mbr_port_i = 4'(bp);  mbr_vid_i = 13'(bvid);
        @(negedge clk);
        miss_vld_i = 0; mbr_vld_i = 0;
    endtask

    task automatic cmd(input logic [2:0] op);
        @(negedge clk);
        cmd_vld_i = 1; cmd_op_i = op;
        @(negedge clk);
        cmd_vld_i = 0;
    endtask

    task automatic t_reset;
        chk({15'd0, irq_o}, 16'd0, "R1 irq");
        chk({15'd0, done_o}, 16'd0, "R1 done");
        chk(op_reg_o, 16'h0000, "R1 op");
        chk(vid_reg_o, 16'h0000, "R1 vid");
    endtask

    task automatic t_miss;
        evt(1, 5, 'h123, 0, 0, 0);
        chk({15'd0, irq_o}, 16'd1, "R2 irq set");
        cmd(3'b111);
        chk({15'd0, done_o}, 16'd1, "R5 done");
        chk(op_reg_o, 16'h7205, "R2 op");
        chk(vid_reg_o, 16'h0123, "R4 vid");
        chk({15'd0, irq_o}, 16'd0, "R6 irq clear");
        @(negedge clk);
        chk({15'd0, done_o}, 16'd0, "R5 done one cycle");
    endtask

    task automatic t_member;
        evt(0, 0, 0, 1, 10, 'h1ABC);
        cmd(3'b111);
        chk(op_reg_o, 16'h710A, "R3 op");
        chk(vid_reg_o, 16'h2ABC, "R4 page bit");
    endtask

    task automatic t_overflow;
        evt(1, 2, 'h010, 0, 0, 0);
        evt(0, 0, 0, 1, 3, 'h020);
        cmd(3'b111);
        chk(op_reg_o, 16'h7602, "R7 op ovf");
        chk(vid_reg_o, 16'h0010, "R7 vid first");
        cmd(3'b111);
        chk(op_reg_o, 16'h7000, "R11 empty op / R7 ovf cleared");
        chk(vid_reg_o, 16'h0000, "R11 empty vid");
    endtask

    task automatic t_same_cycle_diff;
        evt(1, 7, 'h077, 1, 4, 'h044);
        cmd(3'b111);
        chk(op_reg_o, 16'h7504, "R8 op");
        chk(vid_reg_o, 16'h0044, "R8 vid");
    endtask

    task automatic t_same_cycle_same;
        evt(1, 6, 'h066, 1, 6, 'h099);
        cmd(3'b111);
        chk(op_reg_o, 16'h7306, "R9 op");
        chk(vid_reg_o, 16'h0066, "R9 vid");
    endtask

    task automatic t_foreign_op;
        evt(1, 1, 'h005, 0, 0, 0);
        cmd(3'b011);
        chk({15'd0, done_o}, 16'd0, "R12 no done");
        chk({15'd0, irq_o}, 16'd1, "R12 irq kept");
        chk(op_reg_o, 16'h7306, "R12 op unchanged");
        chk(vid_reg_o, 16'h0066, "R12 vid unchanged");
        cmd(3'b111);
        chk(op_reg_o, 16'h7201, "R12 held kept");
        chk(vid_reg_o, 16'h0005, "R12 vid kept");
    endtask

    task automatic t_clear_collide;
        evt(1, 9, 'h0AA, 0, 0, 0);
        @(negedge clk);
        cmd_vld_i = 1; cmd_op_i = 3'b111;
        miss_vld_i = 1; miss_port_i = 4'd8; miss_vid_i = 13'h0BB;
        @(negedge clk);
        cmd_vld_i = 0; miss_vld_i = 0;
        chk(op_reg_o, 16'h7209, "R10 old op");
        chk(vid_reg_o, 16'h00AA, "R10 old vid");
        chk({15'd0, irq_o}, 16'd1, "R10 irq kept");
        cmd(3'b111);
        chk(op_reg_o, 16'h7208, "R10 new op");
        chk(vid_reg_o, 16'h00BB, "R10 new vid");
        chk({15'd0, irq_o}, 16'd0, "R6 irq low");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_miss();
        t_member();
        t_overflow();
        t_same_cycle_diff();
        t_same_cycle_same();
        t_foreign_op();
        t_clear_collide();
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog act=hung exp=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule